// File: doc/BRIEF.md
# Bus Fault Status Capture

This block records why and where a memory access failed. The address translator sends it a one-cycle fault pulse. With the pulse come the fault kind, the direction, whether the access was word or long, the access address, and the parity-interrupt-enable flag. On that pulse the block loads up to three 16-bit status words. It also raises a one-cycle bus-error request toward the processor one clock later. Software reads the three words through plain read ports. A clear strobe, driven by the address decoder when the clear-status location is written, sets all three words to all ones.

The general status word holds a fixed code chosen by fault kind and direction. Two fault kinds (kernel area, write protect) leave it untouched. The high bus status word holds an access-shape code in its upper byte: word/long, odd byte or even byte. The address bits above bit 15 are merged into its lower byte. The low bus status word holds the lower sixteen address bits.

A small two-state sequencer drives the bus-error request. It has two states. ST_IDLE is entered from reset and left on a sampled fault. ST_REPORT asserts the request; it stays in ST_REPORT when another fault is sampled and otherwise returns to ST_IDLE. Its transitions are T_FAULT (ST_IDLE to ST_REPORT), T_AGAIN (ST_REPORT to itself) and T_DONE (ST_REPORT to ST_IDLE).

Top module: `bus_fault_status`

## Requirements
- R1: After reset, gstat, bstat_hi and bstat_lo all read 0xFFFF and bus_err is 0.
- R2: A fault of kind 0 (page absent) loads gstat with 0x8BFF when flt_write is 1 and with 0xCBFF when flt_write is 0 (par_irq_en low).
- R3: A fault of kind 1 (user I/O violation) loads gstat with 0x9AFF when flt_write is 1 and with 0xDAFF when flt_write is 0 (par_irq_en low).
- R4: For kinds 0 and 1, par_irq_en high sets bit 10 (0x0400) in the value loaded into gstat.
- R5: Faults of kind 2 (kernel area) and kind 3 (write protect) leave gstat unchanged but still load bstat_hi and bstat_lo and raise bus_err.
- R6: On any fault, bstat_hi[15:8] becomes 0x7C when flt_wide is 1. When flt_wide is 0 it becomes 0x7D if flt_addr[0] is 1, and 0x7E if flt_addr[0] is 0.
- R7: On any fault, bstat_hi[7:0] becomes flt_addr[23:16], zero-extended when the address is narrower.
- R8: On any fault, bstat_lo becomes flt_addr[15:0].
- R9: clr_stb without a fault sets all three words to 0xFFFF on the next clock.
- R10: When clr_stb and a fault arrive in the same cycle, every word the fault loads takes the fault value. A gstat that the fault kind leaves alone takes 0xFFFF.
- R11: bus_err is high in exactly the cycle after each sampled fault and low otherwise; faults on consecutive cycles keep it high for each of them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flt_valid | input | 1 | One-cycle fault pulse from the translator |
| flt_kind | input | 2 | 0 page absent, 1 user I/O, 2 kernel area, 3 write protect |
| flt_write | input | 1 | 1 for a write access, 0 for a read |
| flt_wide | input | 1 | 1 for a word or long access, 0 for a byte |
| flt_addr | input | ADDR_W | Address of the faulting access |
| par_irq_en | input | 1 | Parity interrupt enable flag |
| clr_stb | input | 1 | Clear-status strobe |
| gstat | output | 16 | General status word |
| bstat_hi | output | 16 | Bus status word: access shape and upper address |
| bstat_lo | output | 16 | Bus status word: lower address |
| bus_err | output | 1 | Bus-error request pulse |

## Verification
The assertions assume flt_kind, flt_write, flt_wide, flt_addr and par_irq_en are settled whenever flt_valid is high. They also assume reset is held for at least one clock before any fault or clear. The bench changes every input only on the falling clock edge and holds reset for several cycles before the first stimulus. It drives fault qualifiers only in the same half-cycle as the pulse. Clear and fault collisions, and back-to-back faults, are produced on purpose and nowhere else.

// File: rtl/bfs_pkg.sv
package bfs_pkg;

    typedef enum logic [1:0] {
        FK_PAGE_ABSENT = 2'd0,
        FK_USER_IO     = 2'd1,
        FK_KERNEL_AREA = 2'd2,
        FK_WRITE_PROT  = 2'd3
    } fault_kind_e;

    typedef enum logic {
        ST_IDLE   = 1'b0,
        ST_REPORT = 1'b1
    } seq_state_e;

    localparam logic [15:0] STAT_CLEARED  = 16'hFFFF;
    localparam logic [15:0] GS_PAGE_WR    = 16'h8BFF;
    localparam logic [15:0] GS_PAGE_RD    = 16'hCBFF;
    localparam logic [15:0] GS_UIO_WR     = 16'h9AFF;
    localparam logic [15:0] GS_UIO_RD     = 16'hDAFF;
    localparam logic [15:0] GS_PARITY_BIT = 16'h0400;

    localparam logic [7:0] BS_WIDE     = 8'h7C;
    localparam logic [7:0] BS_ODD_BYTE = 8'h7D;
    localparam logic [7:0] BS_EVN_BYTE = 8'h7E;

endpackage

// File: rtl/bfs_gstat_enc.sv
module bfs_gstat_enc
    import bfs_pkg::*;
(
    input  fault_kind_e kind,
    input  logic        is_write,
    input  logic        parity_en,
    output logic        load,
    output logic [15:0] code
);

    logic [15:0] base;

    always_comb begin
        load = 1'b0;
        base = STAT_CLEARED;
        unique case (kind)
            FK_PAGE_ABSENT: begin
                load = 1'b1;
                base = is_write ? GS_PAGE_WR : GS_PAGE_RD;
            end
            FK_USER_IO: begin
                load = 1'b1;
                base = is_write ? GS_UIO_WR : GS_UIO_RD;
            end
            FK_KERNEL_AREA,
            FK_WRITE_PROT: begin
                load = 1'b0;
                base = STAT_CLEARED;
            end
        endcase
        code = parity_en ? (base | GS_PARITY_BIT) : base;
    end

endmodule

// File: rtl/bfs_bstat_enc.sv
module bfs_bstat_enc
    import bfs_pkg::*;
#(
    parameter int ADDR_W = 24
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              wide,
    output logic [15:0]       hi_word,
    output logic [15:0]       lo_word
);

    localparam int UP_W = ADDR_W - 16;

    logic [7:0] shape;
    logic [7:0] upper;

    always_comb begin
        if (wide)
            shape = BS_WIDE;
        else if (addr[0])
            shape = BS_ODD_BYTE;
        else
            shape = BS_EVN_BYTE;
    end

    generate
        if (UP_W >= 8) begin : g_full_upper
            assign upper = addr[23:16];
        end else begin : g_part_upper
            assign upper = {{(8-UP_W){1'b0}}, addr[ADDR_W-1:16]};
        end
    endgenerate

    assign hi_word = {shape, 8'h00} | {8'h00, upper};
    assign lo_word = addr[15:0];

endmodule

// File: rtl/bfs_seq.sv
module bfs_seq
    import bfs_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic fault,
    output logic berr
);

    seq_state_e state_q;
    seq_state_e state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (fault) state_d = ST_REPORT;           // T_FAULT
            ST_REPORT: state_d = fault ? ST_REPORT : ST_IDLE;    // T_AGAIN / T_DONE
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    always_comb begin
        berr = 1'b0;
        unique case (state_q)
            ST_IDLE:   berr = 1'b0;
            ST_REPORT: berr = 1'b1;
        endcase
    end

endmodule

// File: rtl/bus_fault_status.sv
module bus_fault_status
    import bfs_pkg::*;
#(
    parameter int ADDR_W = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flt_valid,
    input  logic [1:0]        flt_kind,
    input  logic              flt_write,
    input  logic              flt_wide,
    input  logic [ADDR_W-1:0] flt_addr,
    input  logic              par_irq_en,
    input  logic              clr_stb,
    output logic [15:0]       gstat,
    output logic [15:0]       bstat_hi,
    output logic [15:0]       bstat_lo,
    output logic              bus_err
);

    logic        g_load;
    logic [15:0] g_code;
    logic [15:0] hi_code;
    logic [15:0] lo_code;
    logic [15:0] gstat_q, bhi_q, blo_q;

    bfs_gstat_enc u_genc (
        .kind      (fault_kind_e'(flt_kind)),
        .is_write  (flt_write),
        .parity_en (par_irq_en),
        .load      (g_load),
        .code      (g_code)
    );

    bfs_bstat_enc #(.ADDR_W(ADDR_W)) u_benc (
        .addr    (flt_addr),
        .wide    (flt_wide),
        .hi_word (hi_code),
        .lo_word (lo_code)
    );

    bfs_seq u_seq (
        .clk   (clk),
        .rst_n (rst_n),
        .fault (flt_valid),
        .berr  (bus_err)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gstat_q <= STAT_CLEARED;
            bhi_q   <= STAT_CLEARED;
            blo_q   <= STAT_CLEARED;
        end else begin
            if (flt_valid && g_load)
                gstat_q <= g_code;
            else if (clr_stb)
                gstat_q <= STAT_CLEARED;

            if (flt_valid) begin
                bhi_q <= hi_code;
                blo_q <= lo_code;
            end else if (clr_stb) begin
                bhi_q <= STAT_CLEARED;
                blo_q <= STAT_CLEARED;
            end
        end
    end

    assign gstat    = gstat_q;
    assign bstat_hi = bhi_q;
    assign bstat_lo = blo_q;

endmodule

// File: rtl/bfs_checker.sv
module bfs_checker #(
    parameter int ADDR_W = 24
) (
    input logic              clk,
    input logic              rst_n,
    input logic              flt_valid,
    input logic [1:0]        flt_kind,
    input logic              flt_write,
    input logic              flt_wide,
    input logic [ADDR_W-1:0] flt_addr,
    input logic              par_irq_en,
    input logic              clr_stb,
    input logic [15:0]       gstat,
    input logic [15:0]       bstat_hi,
    input logic [15:0]       bstat_lo,
    input logic              bus_err
);

    p_err_after_fault_r11: assert property (@(posedge clk) disable iff (!rst_n)
        flt_valid |=> bus_err);

    p_err_has_cause_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !flt_valid |=> !bus_err);

    p_lo_capture_r8: assert property (@(posedge clk) disable iff (!rst_n)
        flt_valid |=> (bstat_lo == $past(flt_addr[15:0])));

    p_wide_shape_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (flt_valid && flt_wide) |=> (bstat_hi[15:8] == 8'h7C));

    p_gstat_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (flt_valid && flt_kind[1] && !clr_stb) |=> $stable(gstat));

    p_parity_bit_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (flt_valid && !flt_kind[1] && par_irq_en) |=> gstat[10]);

    p_clear_all_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_stb && !flt_valid) |=>
            (gstat == 16'hFFFF && bstat_hi == 16'hFFFF && bstat_lo == 16'hFFFF));

    p_unused_dir: assert property (@(posedge clk) disable iff (!rst_n)
        (flt_valid && flt_kind == 2'd0 && flt_write && !par_irq_en) |=> (gstat == 16'h8BFF));

endmodule

bind bus_fault_status bfs_checker #(.ADDR_W(ADDR_W)) i_chk (.*);

// File: tb/test_bus_fault_status.sv
module test_bus_fault_status;

    localparam int ADDR_W = 24;
    localparam int NVEC   = 8;
    // {kind[2], write, wide, pie, addr[24], exp_gstat[16]} = 45 bits
    localparam logic [44:0] VEC [NVEC] = '{
        {2'd0, 1'b1, 1'b1, 1'b0, 24'h123456, 16'h8BFF},
        {2'd0, 1'b0, 1'b0, 1'b1, 24'h0A0001, 16'hCFFF},
        {2'd1, 1'b1, 1'b0, 1'b0, 24'h456780, 16'h9AFF},
        {2'd1, 1'b0, 1'b1, 1'b1, 24'hFFFFFE, 16'hDEFF},
        {2'd2, 1'b0, 1'b0, 1'b0, 24'h030011, 16'hDEFF},
        {2'd3, 1'b1, 1'b1, 1'b1, 24'h200000, 16'hDEFF},
        {2'd0, 1'b1, 1'b0, 1'b1, 24'h3FF001, 16'h8FFF},
        {2'd1, 1'b1, 1'b1, 1'b1, 24'h801234, 16'h9EFF}
    };

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              flt_valid = 1'b0;
    logic [1:0]        flt_kind = 2'd0;
    logic              flt_write = 1'b0;
    logic              flt_wide = 1'b0;
    logic [ADDR_W-1:0] flt_addr = '0;
    logic              par_irq_en = 1'b0;
    logic              clr_stb = 1'b0;
    logic [15:0]       gstat, bstat_hi, bstat_lo;
    logic              bus_err;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;

    bus_fault_status #(.ADDR_W(ADDR_W)) i_bus_fault_status (
        .clk(clk), .rst_n(rst_n), .flt_valid(flt_valid), .flt_kind(flt_kind),
        .flt_write(flt_write), .flt_wide(flt_wide), .flt_addr(flt_addr),
        .par_irq_en(par_irq_en), .clr_stb(clr_stb), .gstat(gstat),
        .bstat_hi(bstat_hi), .bstat_lo(bstat_lo), .bus_err(bus_err)
    );

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%04h expected 0x%04h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] model_hi(input logic wide, input logic [ADDR_W-1:0] a);
        logic [7:0] s;
        s = wide ? 8'h7C : (a[0] ? 8'h7D : 8'h7E);
        return {s, a[23:16]};
    endfunction

    task automatic fault(input logic [1:0] k, input logic wr, input logic wd,
                         input logic pie, input logic [ADDR_W-1:0] a, input logic clr);
        flt_valid = 1'b1; flt_kind = k; flt_write = wr; flt_wide = wd;
        par_irq_en = pie; flt_addr = a; clr_stb = clr;
        @(negedge clk);
        flt_valid = 1'b0; clr_stb = 1'b0;
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        #200000;
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            finish_run();
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        // R1 reset state
        check("R1 gstat", gstat, 16'hFFFF);
        check("R1 bstat_hi", bstat_hi, 16'hFFFF);
        check("R1 bstat_lo", bstat_lo, 16'hFFFF);
        check("R1 bus_err", {15'd0, bus_err}, 16'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // table walk: R2 R3 R4 R5 R6 R7 R8 R11
        for (int i = 0; i < NVEC; i++) begin
            logic [1:0]  k;
            logic        wr, wd, pie;
            logic [23:0] a;
            logic [15:0] eg;
            {k, wr, wd, pie, a, eg} = VEC[i];
            fault(k, wr, wd, pie, a, 1'b0);
            check("R2/R3/R4/R5 gstat", gstat, eg);
            check("R6/R7 bstat_hi", bstat_hi, model_hi(wd, a));
            check("R8 bstat_lo", bstat_lo, a[15:0]);
            check("R11 bus_err high", {15'd0, bus_err}, 16'd1);
            @(negedge clk);
            check("R11 bus_err low", {15'd0, bus_err}, 16'd0);
        end

        // R9 clear alone
        clr_stb = 1'b1;
        @(negedge clk);
        clr_stb = 1'b0;
        check("R9 gstat", gstat, 16'hFFFF);
        check("R9 bstat_hi", bstat_hi, 16'hFFFF);
        check("R9 bstat_lo", bstat_lo, 16'hFFFF);
        check("R9 no bus_err", {15'd0, bus_err}, 16'd0);

        // R10 fault beats clear
        fault(2'd0, 1'b1, 1'b1, 1'b0, 24'h012345, 1'b1);
        check("R10 gstat", gstat, 16'h8BFF);
        check("R10 bstat_hi", bstat_hi, 16'h7C01);
        check("R10 bstat_lo", bstat_lo, 16'h2345);
        @(negedge clk);
        // R10 kernel fault with clear: gstat cleared, bus words captured
        fault(2'd2, 1'b0, 1'b0, 1'b0, 24'h050002, 1'b1);
        check("R10 gstat kernel", gstat, 16'hFFFF);
        check("R10 bstat_hi kernel", bstat_hi, 16'h7E05);
        check("R10 bstat_lo kernel", bstat_lo, 16'h0002);
        @(negedge clk);

        // R11 back-to-back faults
        flt_valid = 1'b1; flt_kind = 2'd1; flt_write = 1'b0; flt_wide = 1'b0;
        par_irq_en = 1'b0; flt_addr = 24'h0F0003;
        @(negedge clk);
        check("R11 first of pair", {15'd0, bus_err}, 16'd1);
        flt_kind = 2'd3; flt_addr = 24'h0E0004;
        @(negedge clk);
        flt_valid = 1'b0;
        check("R11 second of pair", {15'd0, bus_err}, 16'd1);
        check("R5 gstat kept", gstat, 16'hDAFF);
        check("R6 even byte", bstat_hi, 16'h7E0E);
        @(negedge clk);
        check("R11 pair ends", {15'd0, bus_err}, 16'd0);

        done = 1'b1;
        finish_run();
    end

endmodule